// File: doc/BRIEF.md
# Stackable Test Access Port with Upward Chain Extension

This block is the boundary-scan test access port of a single die that may sit anywhere in a vertical stack of dies. It runs the standard sixteen-state controller on TMS sampled at rising TCK, holds a 4-bit instruction register, and drives three data registers: a one-bit bypass, a 32-bit identification register, and a one-bit stack-link register. Every die carries the same block, so a die on its own, at wafer probe or in a single-die package, is reached through the same four pins and behaves the same way.

The TCK and TMS pins arrive from the die below, or from the package pins for the bottom die. They are passed straight up to the die above. The die above gets its reset only while this die's stack-link bit is set. When the link is set, the serial output of this die's selected register feeds the upper die's TDI. The upper die's TDO then becomes this die's TDO, so the two registers shift as one longer chain. Because each linked die can in turn link the die above it, a stack of any height looks like one test access port from the package pins.

Top module: `stack_tap`

## Requirements
- R1: The controller follows the sixteen-state test access port state diagram on rising TCK. Five TMS-high clocks from any state reach Test-Logic-Reset, and a low TRST_N forces that state at once.
- R2: Capture-IR loads the instruction shift register with 4'b0001, and Shift-IR presents it least significant bit first. Update-IR makes the shifted value the active instruction.
- R3: In Test-Logic-Reset the active instruction becomes IDCODE (4'b0010). With IDCODE active, Capture-DR loads the 32-bit IDCODE_VAL parameter, and Shift-DR presents it least significant bit first.
- R4: With BYPASS (4'b1111) active, the data path is one bit long, captures 0, and delays TDI by one clock.
- R5: Any instruction code other than 4'b1111, 4'b0010 and 4'b0110 behaves exactly like BYPASS.
- R6: With STACK_EN (4'b0110) active, the data path is the one-bit stack-link register. Capture-DR reads the current link state, and Update-DR writes the shifted bit into it. At no other time does the link state change, except through R10.
- R7: While the link state is clear, up_trst_n is low, and TDO carries only this die's selected register.
- R8: While the link state is set, up_trst_n follows trst_n. The selected local register (instruction or data) is followed in series by the upper die's chain. TDO then shows the upper die's bits first, and then this die's bits.
- R9: A linked die can link the die above it in turn, so three stacked dies present a single chain of their registers concatenated.
- R10: Reaching Test-Logic-Reset, or asserting trst_n low, clears the link state.
- R11: TDO and tdo_en change only on falling TCK. Outside Shift-IR and Shift-DR, tdo_en is low and TDO is driven 0.
- R12: up_tck and up_tms follow tck and tms. up_tdi carries the serial output of this die's selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock from below |
| tms | input | 1 | Test mode select from below |
| tdi | input | 1 | Serial data in from below |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out toward the die below |
| tdo_en | output | 1 | High while TDO carries valid shift data |
| up_tck | output | 1 | Test clock passed to the die above |
| up_tms | output | 1 | Mode select passed to the die above |
| up_tdi | output | 1 | Local register serial output sent to the die above |
| up_trst_n | output | 1 | Reset for the die above, low while the link state is clear |
| up_tdo | input | 1 | Serial data returned by the die above |

## Verification
The hardest case to reach from the pins is a three-die chain in which the middle die has itself been linked. Reaching it takes a full instruction scan through two linked dies, a data scan that writes only the middle die's link bit, and one idle clock so the top die leaves reset in step with the others. The bench stacks three copies of the block, each with its own identification value, and drives that sequence directly. It then checks that a 12-bit instruction capture and a 96-bit identification scan come back in upper-die-first order. It also checks that a trip through Test-Logic-Reset removes both upper dies again.

// File: rtl/stack_tap_pkg.sv
package stack_tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_STACK   = 4'b0110;
    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

    typedef enum logic [3:0] {
        ST_EX2_DR = 4'h0,
        ST_EX1_DR = 4'h1,
        ST_SH_DR  = 4'h2,
        ST_PAU_DR = 4'h3,
        ST_SEL_IR = 4'h4,
        ST_UPD_DR = 4'h5,
        ST_CAP_DR = 4'h6,
        ST_SEL_DR = 4'h7,
        ST_EX2_IR = 4'h8,
        ST_EX1_IR = 4'h9,
        ST_SH_IR  = 4'hA,
        ST_PAU_IR = 4'hB,
        ST_RTI    = 4'hC,
        ST_UPD_IR = 4'hD,
        ST_CAP_IR = 4'hE,
        ST_TLR    = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {
        DSEL_BYP = 2'd0,
        DSEL_ID  = 2'd1,
        DSEL_EN  = 2'd2
    } dr_sel_e;

endpackage

// File: rtl/stack_tap_fsm.sv
module stack_tap_fsm
    import stack_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_TLR:    r_d.st = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    r_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: r_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: r_d.st = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r_d.st = tms ? ST_SEL_DR : ST_RTI;
            default:   r_d.st = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: ST_TLR};
        else         r_q <= r_d;
    end

    assign state_q = r_q.st;

    // R1: holding TMS high keeps the controller parked in Test-Logic-Reset
    a_r1_tlr_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_TLR && tms) |=> (r_q.st == ST_TLR));

    // R1: a Shift-DR with TMS low stays in Shift-DR
    a_r1_shift_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_SH_DR && !tms) |=> (r_q.st == ST_SH_DR));

endmodule

// File: rtl/stack_tap_ir.sv
module stack_tap_ir
    import stack_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output dr_sel_e         dr_sel,
    output logic            ir_so
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] op;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_TLR:    r_d.op = OP_IDCODE;
            ST_CAP_IR: r_d.sh = IR_CAPTURE;
            ST_SH_IR:  r_d.sh = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.op = r_q.sh;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: '0, op: OP_IDCODE};
        else         r_q <= r_d;
    end

    always_comb begin
        case (r_q.op)
            OP_IDCODE: dr_sel = DSEL_ID;
            OP_STACK:  dr_sel = DSEL_EN;
            default:   dr_sel = DSEL_BYP;
        endcase
    end

    assign ir_q  = r_q.op;
    assign ir_so = r_q.sh[0];

    // R2: the clock leaving Capture-IR leaves the fixed capture pattern in place
    a_r2_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (r_q.sh == IR_CAPTURE));

    // R3: Test-Logic-Reset selects the identification instruction
    a_r3_idcode_after_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/stack_tap_dr.sv
module stack_tap_dr
    import stack_tap_pkg::*;
#(
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h0B57_A001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  dr_sel_e    dr_sel,
    input  logic       tdi,
    output logic       dr_so,
    output logic       link_q
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id_sh;
        logic            link_sh;
        logic            link;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_TLR: r_d.link = 1'b0;
            ST_CAP_DR: begin
                case (dr_sel)
                    DSEL_ID: r_d.id_sh   = IDCODE_VAL;
                    DSEL_EN: r_d.link_sh = r_q.link;
                    default: r_d.byp     = 1'b0;
                endcase
            end
            ST_SH_DR: begin
                case (dr_sel)
                    DSEL_ID: r_d.id_sh   = {tdi, r_q.id_sh[ID_W-1:1]};
                    DSEL_EN: r_d.link_sh = tdi;
                    default: r_d.byp     = tdi;
                endcase
            end
            ST_UPD_DR: begin
                if (dr_sel == DSEL_EN) r_d.link = r_q.link_sh;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        case (dr_sel)
            DSEL_ID: dr_so = r_q.id_sh[0];
            DSEL_EN: dr_so = r_q.link_sh;
            default: dr_so = r_q.byp;
        endcase
    end

    assign link_q = r_q.link;

    // R6: the link state moves only on an Update-DR of the stack-link register
    a_r6_link_sticky: assert property (@(posedge tck) disable iff (!trst_n)
        (!(state == ST_UPD_DR && dr_sel == DSEL_EN) && state != ST_TLR)
        |=> $stable(r_q.link));

    // R10: Test-Logic-Reset drops the link
    a_r10_tlr_clears: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> !r_q.link);

endmodule

// File: rtl/stack_tap.sv
module stack_tap
    import stack_tap_pkg::*;
#(
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h0B57_A001
) (
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    input  logic trst_n,
    output logic tdo,
    output logic tdo_en,
    output logic up_tck,
    output logic up_tms,
    output logic up_tdi,
    output logic up_trst_n,
    input  logic up_tdo
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_op;
    dr_sel_e         dr_sel;
    logic            ir_so;
    logic            dr_so;
    logic            link;
    logic            shifting;
    logic            local_so;

    stack_tap_fsm fsm_i (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state)
    );

    stack_tap_ir ir_i (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_q   (ir_op),
        .dr_sel (dr_sel),
        .ir_so  (ir_so)
    );

    stack_tap_dr #(
        .ID_W       (ID_W),
        .IDCODE_VAL (IDCODE_VAL)
    ) dr_i (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .dr_sel (dr_sel),
        .tdi    (tdi),
        .dr_so  (dr_so),
        .link_q (link)
    );

    assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);
    assign local_so = (state == ST_SH_IR) ? ir_so : dr_so;

    // falling-edge output stage
    typedef struct packed {
        logic bit_out;
        logic oe;
        logic sel_up;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d         = o_q;
        o_d.bit_out = shifting & local_so;
        o_d.oe      = shifting;
        o_d.sel_up  = shifting & link;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo       = o_q.sel_up ? up_tdo : o_q.bit_out;
    assign tdo_en    = o_q.oe;
    assign up_tck    = tck;
    assign up_tms    = tms;
    assign up_tdi    = local_so;
    assign up_trst_n = trst_n & link;

    // R11: the output enable is only ever up while the controller shifts
    a_r11_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R7: after a clock in Test-Logic-Reset the upper die is held in reset
    a_r7_upper_held: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> !up_trst_n);

endmodule

// File: tb/stack_tap_tb_top.sv
`timescale 1ns/100ps
module stack_tap_tb_top;
    import stack_tap_pkg::*;

    localparam logic [31:0] ID_A = 32'h1A5C_E0B3;
    localparam logic [31:0] ID_B = 32'h2B6D_F1C5;
    localparam logic [31:0] ID_C = 32'h3C7E_0207;

    logic tck = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic trst_n = 1'b0;

    logic tdo, tdo_en, up_tck, up_tms, up_tdi, up_trst_n;
    logic m_tdo, m_tdo_en, m_up_tck, m_up_tms, m_up_tdi, m_up_trst_n;
    logic t_tdo, t_tdo_en, t_up_tck, t_up_tms, t_up_tdi, t_up_trst_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 tck = ~tck;

    stack_tap #(.ID_W(32), .IDCODE_VAL(ID_A)) dut_i (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .tdo(tdo), .tdo_en(tdo_en),
        .up_tck(up_tck), .up_tms(up_tms), .up_tdi(up_tdi), .up_trst_n(up_trst_n),
        .up_tdo(m_tdo)
    );

    stack_tap #(.ID_W(32), .IDCODE_VAL(ID_B)) mid_i (
        .tck(up_tck), .tms(up_tms), .tdi(up_tdi), .trst_n(up_trst_n),
        .tdo(m_tdo), .tdo_en(m_tdo_en),
        .up_tck(m_up_tck), .up_tms(m_up_tms), .up_tdi(m_up_tdi), .up_trst_n(m_up_trst_n),
        .up_tdo(t_tdo)
    );

    stack_tap #(.ID_W(32), .IDCODE_VAL(ID_C)) top_i (
        .tck(m_up_tck), .tms(m_up_tms), .tdi(m_up_tdi), .trst_n(m_up_trst_n),
        .tdo(t_tdo), .tdo_en(t_tdo_en),
        .up_tck(t_up_tck), .up_tms(t_up_tms), .up_tdi(t_up_tdi), .up_trst_n(t_up_trst_n),
        .up_tdo(1'b0)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        o   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [127:0] vin,
                        output logic [127:0] vout);
        logic o;
        vout = '0;
        tick(1'b1, 1'b0, o);
        if (is_ir) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, vin[i], o);
            vout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    function automatic logic [127:0] exp_single(input logic [3:0] op, input logic [127:0] vin,
                                                input int n);
        logic [127:0] e = '0;
        if (op == OP_IDCODE) begin
            for (int i = 0; i < n; i++) e[i] = (i < 32) ? ID_A[i] : vin[i-32];
        end else begin
            for (int i = 1; i < n; i++) e[i] = vin[i-1];
        end
        return e;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic o;
        logic [127:0] vo, vi;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);

        // reset state
        #9;
        check("R11 tdo_en in reset", {127'b0, tdo_en}, 128'd0);
        check("R11 tdo in reset", {127'b0, tdo}, 128'd0);
        check("R7 up_trst_n in reset", {127'b0, up_trst_n}, 128'd0);
        @(negedge tck);
        trst_n = 1'b1;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R11 tdo_en idle", {127'b0, tdo_en}, 128'd0);
        check("R12 up_tms follows", {127'b0, up_tms}, {127'b0, tms});

        // R3: identification after reset
        vi = {$urandom, $urandom, $urandom, $urandom};
        scan(1'b0, 32, vi, vo);
        check("R3 idcode after reset", vo & 128'hFFFF_FFFF, {96'b0, ID_A});

        // R2: instruction capture
        scan(1'b1, 4, {124'b0, OP_BYPASS}, vo);
        check("R2 ir capture", vo, 128'h1);

        // R11: TDO moves only on falling TCK (bypass, capture 0 then shift 1)
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        @(negedge tck); #1;
        check("R4 bypass capture 0", {127'b0, tdo}, 128'd0);
        tdi = 1'b1; tms = 1'b0;
        @(posedge tck); #0.5;
        check("R11 tdo held after rise", {127'b0, tdo}, 128'd0);
        @(negedge tck); #1;
        check("R11 tdo moves on fall", {127'b0, tdo}, 128'd1);
        check("R12 up_tdi is local out", {127'b0, up_tdi}, 128'd1);
        tms = 1'b1;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);

        // R3 R4 R5: random instructions on a lone die
        for (int k = 0; k < 16; k++) begin
            logic [3:0] op;
            int pick;
            pick = $urandom % 3;
            if (pick == 0) op = OP_BYPASS;
            else if (pick == 1) op = OP_IDCODE;
            else begin
                op = 4'($urandom % 16);
                if (op == OP_BYPASS || op == OP_IDCODE || op == OP_STACK) op = 4'b0101;
            end
            scan(1'b1, 4, {124'b0, op}, vo);
            check("R2 ir capture random", vo, 128'h1);
            vi = {$urandom, $urandom, $urandom, $urandom};
            scan(1'b0, 36, vi, vo);
            check(pick == 2 ? "R5 unknown code as bypass" :
                  (pick == 0 ? "R4 bypass delay" : "R3 idcode scan"),
                  vo, exp_single(op, vi, 36));
        end

        // R6 R7: link register reads clear, then set it
        scan(1'b1, 4, {124'b0, OP_STACK}, vo);
        scan(1'b0, 1, 128'd0, vo);
        check("R6 link capture clear", vo, 128'd0);
        check("R7 upper held while clear", {127'b0, up_trst_n}, 128'd0);
        scan(1'b0, 1, 128'd1, vo);
        tick(1'b0, 1'b0, o);
        check("R8 upper released", {127'b0, up_trst_n}, 128'd1);
        scan(1'b0, 1, 128'd1, vo);
        check("R6 link capture set", vo, 128'd1);

        // R8: two-die chain
        scan(1'b1, 8, {120'b0, OP_IDCODE, OP_IDCODE}, vo);
        check("R8 chained ir capture", vo, 128'h11);
        vi = {$urandom, $urandom, $urandom, $urandom};
        scan(1'b0, 64, vi, vo);
        check("R8 chained idcode", vo, {64'b0, ID_A, ID_B});

        // R9: middle die links the top die
        scan(1'b1, 8, {120'b0, OP_BYPASS, OP_STACK}, vo);
        check("R8 ir capture before middle link", vo, 128'h11);
        scan(1'b0, 2, 128'b01, vo);
        check("R9 middle link capture", vo, 128'd0);
        tick(1'b0, 1'b0, o);
        check("R9 top released", {127'b0, m_up_trst_n}, 128'd1);
        scan(1'b1, 12, {116'b0, OP_IDCODE, OP_IDCODE, OP_IDCODE}, vo);
        check("R9 three-die ir capture", vo, 128'h111);
        scan(1'b0, 96, 128'd0, vo);
        check("R9 three-die idcode", vo, {32'b0, ID_A, ID_B, ID_C});

        // R10: Test-Logic-Reset drops the links
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R10 tlr clears link", {127'b0, up_trst_n}, 128'd0);
        scan(1'b1, 4, {124'b0, OP_IDCODE}, vo);
        check("R7 lone ir after tlr", vo, 128'h1);
        scan(1'b0, 32, 128'd0, vo);
        check("R7 lone idcode after tlr", vo, {96'b0, ID_A});

        // relink bottom only; middle link must have been cleared too
        scan(1'b1, 4, {124'b0, OP_STACK}, vo);
        scan(1'b0, 1, 128'd1, vo);
        tick(1'b0, 1'b0, o);
        scan(1'b1, 8, {120'b0, OP_IDCODE, OP_IDCODE}, vo);
        check("R10 relinked ir chain", vo, 128'h11);
        scan(1'b0, 64, 128'd0, vo);
        check("R10 middle link cleared", vo, {64'b0, ID_A, ID_B});

        // R10: asynchronous test reset
        @(negedge tck); #1;
        trst_n = 1'b0;
        #1;
        check("R10 trst clears link", {127'b0, up_trst_n}, 128'd0);
        check("R11 tdo_en under trst", {127'b0, tdo_en}, 128'd0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        tms = 1'b0;
        tick(1'b0, 1'b0, o);
        scan(1'b1, 4, {124'b0, OP_IDCODE}, vo);
        check("R1 ir after trst", vo, 128'h1);
        scan(1'b0, 32, 128'd0, vo);
        check("R3 idcode after trst", vo, {96'b0, ID_A});

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule